// File: doc/BRIEF.md
# Host–Subprocessor Bidirectional Mailbox

This block passes 16-bit words between a wide host processor and a byte-wide subprocessor, one mailbox in each direction, each with its own handshake flag. In the downward direction the host writes a word. The write raises a level interrupt request toward the subprocessor and drops a "mail unread" flag. The subprocessor fetches the word as two byte reads. Reading the upper byte marks the mail as taken.

In the upward direction the subprocessor deposits a low byte and a high byte separately. When the host reads the combined word, a single-cycle non-maskable pulse goes to the subprocessor and a "reply consumed" flag drops. The subprocessor raises that flag again by writing any value to a dedicated acknowledge port. The host watches both flags through a status word.

Top module: `hsmbox_top`

## Requirements
- R1: After reset both latches hold zero, `sub_irq` and `sub_nmi` are 0, and `host_status` reads 0x0050 (both flags 1).
- R2: A `host_wr` cycle stores all of `host_wdata` into the downward latch. From the next cycle, a subprocessor read of address 0 returns bits 7:0 and a read of address 1 returns bits 15:8.
- R3: A `host_wr` cycle sets `sub_irq` from the next cycle. It stays 1 until a cycle with `sub_iack` high and no `host_wr`. When both occur in the same cycle, the write wins and `sub_irq` stays 1.
- R4: A `host_wr` cycle clears the mail flag (`host_status` bit 4) to 0 on the next cycle. This holds even if an address-1 read happens in the same cycle.
- R5: A subprocessor read of address 1 sets the mail flag to 1 on the next cycle. A read of address 0 leaves the flag unchanged.
- R6: A subprocessor write to address 2 loads the upward low byte and a write to address 3 loads the upward high byte. Each leaves the other byte unchanged. `host_rdata` always shows {high, low}.
- R7: A `host_rd` cycle drives `sub_nmi` high for exactly the next cycle. A `host_rd` arriving while `sub_nmi` is already high does not start another pulse.
- R8: A `host_rd` cycle clears the reply flag (`host_status` bit 6) to 0. A subprocessor write to address 4 sets it to 1, whatever the data. When both occur in the same cycle, the clear wins.
- R9: `host_status` bits other than 4 and 6 are always 0.
- R10: Subprocessor accesses to addresses 5–7 read back 0 and change no latch, flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host word write strobe to the downward latch |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe of the upward word (side effects) |
| host_rdata | output | 16 | Upward word {high, low} |
| host_status | output | 16 | Bit 4 mail flag, bit 6 reply flag |
| sub_cs | input | 1 | Subprocessor access strobe |
| sub_we | input | 1 | 1 = write, 0 = read |
| sub_addr | input | 3 | Subprocessor port address |
| sub_wdata | input | 8 | Subprocessor write data |
| sub_rdata | output | 8 | Subprocessor read data |
| sub_iack | input | 1 | Subprocessor interrupt acknowledge |
| sub_irq | output | 1 | Held interrupt request to subprocessor |
| sub_nmi | output | 1 | One-cycle NMI pulse to subprocessor |

## Verification
A corrupted downward latch shows up on the very next byte read of address 0 or 1. A wrong upward byte shows on `host_rdata` combinationally, one cycle after the byte write. Flag errors appear in `host_status` one cycle after the access that should have moved them, so every side-effect access is followed by a status sample. A retriggering or stretched NMI shows as `sub_nmi` being high on two consecutive cycles under a held `host_rd`.

// File: rtl/hsmbox_pkg.sv
package hsmbox_pkg;
    parameter int HOST_W = 16;
    parameter int SUB_W  = 8;
    parameter int ADDR_W = 3;
    localparam int LANES = HOST_W / SUB_W;

    localparam logic [ADDR_W-1:0] A_DN_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DN_HI  = 3'd1;
    localparam logic [ADDR_W-1:0] A_UP_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_UP_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_ACK    = 3'd4;

    localparam int MAIL_BIT  = 4;
    localparam int REPLY_BIT = 6;

    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic wr_lo;
        logic wr_hi;
        logic wr_ack;
    } sub_strobe_t;

    function automatic logic [HOST_W-1:0] pack_status(input logic mail, input logic reply);
        logic [HOST_W-1:0] s;
        s = '0;
        s[MAIL_BIT]  = mail;
        s[REPLY_BIT] = reply;
        return s;
    endfunction
endpackage

// File: rtl/hsmbox_decode.sv
module hsmbox_decode
    import hsmbox_pkg::*;
(
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output sub_strobe_t       stb
);
    always_comb begin
        stb        = '0;
        stb.rd_lo  = cs && !we && (addr == A_DN_LO);
        stb.rd_hi  = cs && !we && (addr == A_DN_HI);
        stb.wr_lo  = cs &&  we && (addr == A_UP_LO);
        stb.wr_hi  = cs &&  we && (addr == A_UP_HI);
        stb.wr_ack = cs &&  we && (addr == A_ACK);
    end
endmodule

// File: rtl/hsmbox_down.sv
module hsmbox_down
    import hsmbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_wdata,
    input  sub_strobe_t       stb,
    input  logic              iack,
    output logic [HOST_W-1:0] latch,
    output logic              irq,
    output logic              mail_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch     <= '0;
            irq       <= 1'b0;
            mail_flag <= 1'b1;
        end else begin
            if (host_wr) latch <= host_wdata;
            if (host_wr)   irq <= 1'b1;
            else if (iack) irq <= 1'b0;
            if (host_wr)        mail_flag <= 1'b0;
            else if (stb.rd_hi) mail_flag <= 1'b1;
        end
    end

    a_r3_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq && !iack) |=> irq);
    a_r3_write_raises: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> irq);
    a_r4_mail_clears: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> !mail_flag);
    a_r5_hi_read_sets: assert property (@(posedge clk) disable iff (rst)
        (stb.rd_hi && !host_wr) |=> mail_flag);
    a_r2_latch_stable: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> $stable(latch));
endmodule

// File: rtl/hsmbox_up.sv
module hsmbox_up
    import hsmbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rd,
    input  sub_strobe_t       stb,
    input  logic [SUB_W-1:0]  wdata,
    output logic [HOST_W-1:0] latch,
    output logic              nmi,
    output logic              reply_flag
);
    logic [LANES-1:0] lane_we;
    assign lane_we = {stb.wr_hi, stb.wr_lo};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)             latch[g*SUB_W +: SUB_W] <= '0;
            else if (lane_we[g]) latch[g*SUB_W +: SUB_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi        <= 1'b0;
            reply_flag <= 1'b1;
        end else begin
            nmi <= host_rd && !nmi;
            if (host_rd)         reply_flag <= 1'b0;
            else if (stb.wr_ack) reply_flag <= 1'b1;
        end
    end

    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !nmi);
    a_r7_read_fires: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !nmi) |=> nmi);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> !reply_flag);
    a_r6_up_stable: assert property (@(posedge clk) disable iff (rst)
        !(stb.wr_lo || stb.wr_hi) |=> $stable(latch));
endmodule

// File: rtl/hsmbox_top.sv
module hsmbox_top
    import hsmbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [15:0]       host_wdata,
    input  logic              host_rd,
    output logic [15:0]       host_rdata,
    output logic [15:0]       host_status,
    input  logic              sub_cs,
    input  logic              sub_we,
    input  logic [2:0]        sub_addr,
    input  logic [7:0]        sub_wdata,
    output logic [7:0]        sub_rdata,
    input  logic              sub_iack,
    output logic              sub_irq,
    output logic              sub_nmi
);
    sub_strobe_t       stb;
    logic [HOST_W-1:0] dn_latch;
    logic [HOST_W-1:0] up_latch;
    logic              mail_flag;
    logic              reply_flag;

    hsmbox_decode u_dec (
        .cs(sub_cs), .we(sub_we), .addr(sub_addr), .stb(stb)
    );

    hsmbox_down u_down (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .stb(stb), .iack(sub_iack), .latch(dn_latch), .irq(sub_irq),
        .mail_flag(mail_flag)
    );

    hsmbox_up u_up (
        .clk(clk), .rst(rst), .host_rd(host_rd), .stb(stb),
        .wdata(sub_wdata), .latch(up_latch), .nmi(sub_nmi),
        .reply_flag(reply_flag)
    );

    always_comb begin
        if (stb.rd_lo)      sub_rdata = dn_latch[SUB_W-1:0];
        else if (stb.rd_hi) sub_rdata = dn_latch[HOST_W-1:SUB_W];
        else                sub_rdata = '0;
    end

    assign host_rdata  = up_latch;
    assign host_status = pack_status(mail_flag, reply_flag);

    a_r9_status_clean: assert property (@(posedge clk) disable iff (rst)
        (host_status & ~16'h0050) == 16'h0000);
    a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
        (sub_cs && sub_addr > 3'd4) |-> sub_rdata == 8'h00);
endmodule

// File: tb/tb_hsmbox_top.sv
module tb_hsmbox_top;
    logic        clk = 0;
    logic        rst;
    logic        host_wr, host_rd, sub_cs, sub_we, sub_iack;
    logic [15:0] host_wdata;
    logic [2:0]  sub_addr;
    logic [7:0]  sub_wdata;
    logic [15:0] host_rdata, host_status;
    logic [7:0]  sub_rdata;
    logic        sub_irq, sub_nmi;
    int          n_vec = 0, n_bad = 0;
    logic        done = 0;

    always #4 clk = ~clk;

    hsmbox_top dut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; sub_cs = 0; sub_we = 0; sub_iack = 0;
        sub_addr = 0; sub_wdata = 0; host_wdata = 0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic sub_acc(input logic we, input logic [2:0] a, input logic [7:0] d);
        sub_cs = 1; sub_we = we; sub_addr = a; sub_wdata = d;
    endtask

    initial begin
        #1200000;
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  lo, hi;
        idle(); rst = 1;
        @(negedge clk); tick(); rst = 0;
        // R1 reset state
        chk("R1 irq", {15'd0, sub_irq}, 16'd0);
        chk("R1 nmi", {15'd0, sub_nmi}, 16'd0);
        chk("R1 status", host_status, 16'h0050);
        chk("R1 up", host_rdata, 16'h0000);
        sub_acc(0, 3'd0, 0); #1 chk("R1 dn lo", {8'd0, sub_rdata}, 16'd0);
        sub_acc(0, 3'd1, 0); #1 chk("R1 dn hi", {8'd0, sub_rdata}, 16'd0);
        idle();

        // Downward sweep: R2 R3 R4 R5
        for (int k = 0; k < 64; k++) begin
            d = 16'(k * 16'h0405) ^ 16'h1F3C;
            host_wr = 1; host_wdata = d; tick(); idle();
            chk("R3 irq after write", {15'd0, sub_irq}, 16'd1);
            chk("R4 mail cleared", host_status, 16'h0040);
            sub_acc(0, 3'd0, 0); #1 chk("R2 low byte", {8'd0, sub_rdata}, {8'd0, d[7:0]});
            tick(); idle();
            chk("R5 low read no effect", host_status, 16'h0040);
            sub_acc(0, 3'd1, 0); #1 chk("R2 high byte", {8'd0, sub_rdata}, {8'd0, d[15:8]});
            tick(); idle();
            chk("R5 high read sets", host_status, 16'h0050);
            chk("R3 irq held", {15'd0, sub_irq}, 16'd1);
            sub_iack = 1; tick(); idle();
            chk("R3 iack drops", {15'd0, sub_irq}, 16'd0);
        end
        // R3 write beats iack
        host_wr = 1; host_wdata = 16'hA55A; sub_iack = 1; tick(); idle();
        chk("R3 write beats iack", {15'd0, sub_irq}, 16'd1);
        // R4 write beats hi read
        sub_acc(0, 3'd1, 0); host_wr = 1; host_wdata = 16'h1234; tick(); idle();
        chk("R4 write beats read", host_status, 16'h0040);
        sub_acc(0, 3'd1, 0); tick(); idle();
        sub_iack = 1; tick(); idle();

        // Upward sweep: R6
        for (int k = 0; k < 32; k++) begin
            lo = 8'(k * 37 + 5); hi = 8'(k * 11 ^ 8'hC3);
            sub_acc(1, 3'd2, lo); tick(); idle();
            sub_acc(1, 3'd3, hi); tick(); idle();
            chk("R6 word", host_rdata, {hi, lo});
            sub_acc(1, 3'd2, ~lo); tick(); idle();
            chk("R6 low only", host_rdata, {hi, ~lo});
        end

        // R7 R8
        host_rd = 1; tick(); idle();
        chk("R7 nmi pulse", {15'd0, sub_nmi}, 16'd1);
        chk("R8 reply cleared", host_status, 16'h0010);
        tick();
        chk("R7 pulse one cycle", {15'd0, sub_nmi}, 16'd0);
        sub_acc(1, 3'd4, 8'h00); tick(); idle();
        chk("R8 ack sets", host_status, 16'h0050);
        host_rd = 1; tick();
        chk("R7 first of held", {15'd0, sub_nmi}, 16'd1);
        tick(); idle();
        chk("R7 no retrigger", {15'd0, sub_nmi}, 16'd0);
        host_rd = 1; sub_acc(1, 3'd4, 8'hFF); tick(); idle();
        chk("R8 clear beats ack", host_status, 16'h0010);
        tick();
        sub_acc(1, 3'd4, 8'h5A); tick(); idle();
        chk("R8 ack any data", host_status, 16'h0050);

        // R10 unmapped
        d = host_rdata;
        for (int a = 5; a < 8; a++) begin
            sub_acc(0, 3'(a), 0); #1 chk("R10 read zero", {8'd0, sub_rdata}, 16'd0);
            tick();
            sub_acc(1, 3'(a), 8'h99); tick(); idle();
            chk("R10 up unchanged", host_rdata, d);
            chk("R10 flags unchanged", host_status, 16'h0050);
            chk("R10 irq unchanged", {15'd0, sub_irq}, 16'd0);
            chk("R10 nmi quiet", {15'd0, sub_nmi}, 16'd0);
        end
        chk("R9 status bits", host_status & ~16'h0050, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule